// File: doc/BRIEF.md
# System Tick Down Counter

This block is a free-running down counter for a periodic operating-system tick or for a software deadline check. It runs on the system clock. A small word-addressed register port gives access to three registers: a control/status word, a reload value and the live count. Once enabled, the counter steps down by one on every clock. When it reaches zero it loads the reload value on the next clock, so one period lasts reload+1 cycles. For example, a 100 Hz tick from a 25 MHz clock uses a reload value of 249999.

Each time the count steps from one to zero, the block records a wrap in a sticky flag. If the tick interrupt is enabled, the same wrap also produces a one-cycle pulse on `tick_irq`. Software can poll the flag to learn whether a programmed interval has expired since it last looked. Reading the control/status word clears the flag. Any write to the count register forces the count to zero and also clears the flag; the data written is discarded.

Top module: `stk_timer`

## Requirements
- R1: After reset the count, reload value, enable bit, interrupt-enable bit, wrap flag and `tick_irq` are all zero.
- R2: While the enable bit (control bit 0) is clear, the count holds its value.
- R3: While enabled and nonzero, the count decreases by exactly one per clock.
- R4: While enabled and at zero, the count loads the reload value on the next clock, giving a period of reload+1 cycles.
- R5: An enabled step from one to zero sets the wrap flag (control bit 16), which stays set until it is cleared.
- R6: A read of the control/status word (word address 0) returns the flag and then clears it; a wrap in the same cycle as the read leaves the flag set.
- R7: A write of any data to the count register (word address 2) makes the count zero and clears the flag on the next clock.
- R8: `tick_irq` is high for exactly the one cycle after each wrap when the interrupt-enable bit (control bit 1) is set, and never when it is clear.
- R9: With a reload value of zero and the count at zero, the count stays at zero and the flag is never set.
- R10: Reads return the live count at word address 2 and the reload value at word address 1, both zero-extended to 32 bits. The control word reads back enable at bit 0, interrupt enable at bit 1 and the flag at bit 16. Only the low 24 bits of a reload write are kept, and a write to bit 16 of the control word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control/status, 1 reload, 2 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| tick_irq | output | 1 | One-cycle tick interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit counter behind a 32-bit data word. Most reload values it programs stay below 16, so wraps, reloads and flag events arrive every few cycles and land on reads and count writes by chance. A full-width reload write brings the 24-bit truncation and zero-extension within reach. Directed steps place a status read exactly on the wrap cycle and hold a zero reload to confirm the idle case.

// File: rtl/stk_pkg.sv
// Package: shared parameters and register decode constants for the tick counter.
// Assumes word addressing on a two-bit address bus.
package stk_pkg;
    localparam int STK_CNT_W  = 24;
    localparam int STK_DATA_W = 32;
    localparam int STK_ADDR_W = 2;

    // Word addresses of the three registers.
    typedef enum logic [STK_ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_NONE   = 2'd3
    } stk_reg_e;

    // Field positions inside the control/status word.
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_FLAG_BIT = 16;
endpackage

// File: rtl/stk_regs.sv
// Module: register file of the tick counter.
// Holds enable, interrupt enable, reload value and the sticky wrap flag,
// and decodes the side effects of bus accesses (count clear, flag clear).
// Assumes one access per cycle, qualified by sel.
module stk_regs
    import stk_pkg::*;
#(
    parameter int CNT_W  = STK_CNT_W,
    parameter int DATA_W = STK_DATA_W,
    parameter int ADDR_W = STK_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap,
    output logic              run,
    output logic              ie,
    output logic [CNT_W-1:0]  reload,
    output logic              flag,
    output logic              cnt_clr
);
    logic ctrl_wr;
    logic ctrl_rd;
    logic reload_wr;

    // Decode the strobes of the current access.
    always_comb begin
        ctrl_wr   = sel && wr  && (addr == REG_CTRL);
        ctrl_rd   = sel && !wr && (addr == REG_CTRL);
        reload_wr = sel && wr  && (addr == REG_RELOAD);
        cnt_clr   = sel && wr  && (addr == REG_COUNT);
    end

    // Control bits: software-written enable and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            ie  <= 1'b0;
        end else if (ctrl_wr) begin
            run <= wdata[CTRL_RUN_BIT];
            ie  <= wdata[CTRL_IE_BIT];
        end
    end

    // Reload value: keeps the low CNT_W bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (reload_wr) begin
            reload <= wdata[CNT_W-1:0];
        end
    end

    // Sticky wrap flag: a wrap wins over a clear by status read or count write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (ctrl_rd || cnt_clr) begin
            flag <= 1'b0;
        end
    end

    // R5: a wrap always leaves the flag set.
    a_r5_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);

    // R5: without a clear source the flag is sticky.
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctrl_rd && !cnt_clr) |=> flag);

    // R6: a status read with no wrap clears the flag.
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !wrap) |=> !flag);
endmodule

// File: rtl/stk_core.sv
// Module: the counting datapath of the tick counter.
// Decrements while enabled, reloads at zero, and reports the step from one
// to zero as a wrap. Registers the tick interrupt pulse.
// Assumes cnt_clr has priority over counting.
module stk_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ie,
    input  logic             cnt_clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             tick
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Wrap event: an enabled step from one down to zero.
    always_comb begin
        wrap = run && !cnt_clr && (cnt == ONE);
    end

    // Counter: clear, reload at zero, otherwise decrement while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_clr) begin
            cnt <= '0;
        end else if (run) begin
            if (cnt == '0) begin
                cnt <= reload;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

    // Tick pulse: one cycle after a wrap when interrupts are enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= wrap && ie;
        end
    end

    // R2: a stopped counter holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_clr) |=> $stable(cnt));

    // R3: an enabled nonzero count steps down by one.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_clr && cnt != '0) |=> (cnt == $past(cnt) - ONE));

    // R4: an enabled zero count takes the reload value.
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_clr && cnt == '0) |=> (cnt == $past(reload)));

    // R7: a count write leaves zero.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt == '0));

    // R8: the tick lasts one cycle and only follows a wrap.
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    a_r8_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick) |-> (cnt == '0));

    // R9: zero reload keeps an idle zero count and raises no wrap.
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && reload == '0 && !cnt_clr) |=> (cnt == '0 && !wrap));
endmodule

// File: rtl/stk_rdmux.sv
// Module: read-data selection for the tick counter registers.
// Combinational; returns zero when no read is strobed or for an unused address.
module stk_rdmux
    import stk_pkg::*;
#(
    parameter int CNT_W  = STK_CNT_W,
    parameter int DATA_W = STK_DATA_W,
    parameter int ADDR_W = STK_ADDR_W
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              run,
    input  logic              ie,
    input  logic              flag,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - CNT_W;

    // Select and zero-extend the addressed register.
    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            case (addr)
                REG_CTRL: begin
                    rdata[CTRL_RUN_BIT]  = run;
                    rdata[CTRL_IE_BIT]   = ie;
                    rdata[CTRL_FLAG_BIT] = flag;
                end
                REG_RELOAD: rdata = {{PAD_W{1'b0}}, reload};
                REG_COUNT:  rdata = {{PAD_W{1'b0}}, cnt};
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/stk_timer.sv
// Module: top of the system tick down counter.
// Connects the register file, counting core and read mux.
// Assumes a synchronous active-low reset and single-cycle register accesses.
module stk_timer
    import stk_pkg::*;
#(
    parameter int CNT_W  = STK_CNT_W,
    parameter int DATA_W = STK_DATA_W,
    parameter int ADDR_W = STK_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);
    logic             run;
    logic             ie;
    logic             flag;
    logic             cnt_clr;
    logic             wrap;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;

    stk_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .wrap    (wrap),
        .run     (run),
        .ie      (ie),
        .reload  (reload),
        .flag    (flag),
        .cnt_clr (cnt_clr)
    );

    stk_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ie      (ie),
        .cnt_clr (cnt_clr),
        .reload  (reload),
        .cnt     (cnt),
        .wrap    (wrap),
        .tick    (tick_irq)
    );

    stk_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .run     (run),
        .ie      (ie),
        .flag    (flag),
        .reload  (reload),
        .cnt     (cnt),
        .rdata   (bus_rdata)
    );

    // R1: the tick output is low in the cycle after reset.
    a_r1_tick_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> !tick_irq);
endmodule

// File: tb/stk_timer_tb.sv
// Bench: reference model plus directed and seeded random register traffic.
module stk_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state.
    logic [23:0] m_cnt = '0;
    logic [23:0] m_rel = '0;
    logic        m_run = 1'b0;
    logic        m_ie = 1'b0;
    logic        m_flag = 1'b0;
    logic        m_tick = 1'b0;

    always #5 clk = ~clk;

    stk_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_irq  (tick_irq)
    );

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            2'd0: begin r[0] = m_run; r[1] = m_ie; r[16] = m_flag; end
            2'd1: r = {8'h0, m_rel};
            2'd2: r = {8'h0, m_cnt};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, check, then advance the model.
    task automatic cyc(input bit sel, input bit wr, input logic [1:0] a,
                       input logic [31:0] wd, input string req);
        bit wrap;
        bit clr;
        bit crd;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
        if (sel && !wr) check(bus_rdata == exp_rd(a), req, bus_rdata, exp_rd(a));
        check(tick_irq == m_tick, "R8", {31'b0, tick_irq}, {31'b0, m_tick});
        @(posedge clk);
        clr  = sel && wr && a == 2'd2;
        crd  = sel && !wr && a == 2'd0;
        wrap = m_run && !clr && m_cnt == 24'd1;
        m_tick = wrap && m_ie;
        if (wrap) m_flag = 1'b1;
        else if (clr || crd) m_flag = 1'b0;
        if (clr) m_cnt = '0;
        else if (m_run) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 24'd1;
        if (sel && wr && a == 2'd0) begin m_run = wd[0]; m_ie = wd[1]; end
        if (sel && wr && a == 2'd1) m_rel = wd[23:0];
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 32'h0, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        cyc(1, 0, 2'd0, 0, "R1");
        cyc(1, 0, 2'd1, 0, "R1");
        cyc(1, 0, 2'd2, 0, "R1");
        // R10: truncation, readback, flag bit not writable.
        cyc(1, 1, 2'd1, 32'hFFFF_FFFF, "R10");
        cyc(1, 0, 2'd1, 0, "R10");
        cyc(1, 1, 2'd0, 32'h0001_0002, "R10");
        cyc(1, 0, 2'd0, 0, "R10");
        cyc(1, 0, 2'd3, 0, "R10");
        // R3/R4: period check with reload 4, tick enabled.
        cyc(1, 1, 2'd1, 32'd4, "R10");
        cyc(1, 1, 2'd2, 0, "R7");
        cyc(1, 1, 2'd0, 32'd3, "R10");
        for (int i = 0; i < 12; i++) cyc(1, 0, 2'd2, 0, "R3 R4");
        // R5/R6: flag seen, then cleared by the read.
        cyc(1, 0, 2'd0, 0, "R5");
        cyc(1, 0, 2'd0, 0, "R6");
        // R6: status read landing on the wrap cycle.
        while (!(m_cnt == 24'd1)) cyc(0, 0, 2'd0, 0, "R8");
        cyc(1, 0, 2'd0, 0, "R6");
        cyc(1, 0, 2'd0, 0, "R6");
        // R2: stop and hold.
        cyc(1, 1, 2'd0, 32'd0, "R2");
        idle(5);
        cyc(1, 0, 2'd2, 0, "R2");
        // R7: count write with junk data clears count and flag.
        cyc(1, 1, 2'd0, 32'd1, "R7");
        idle(8);
        cyc(1, 1, 2'd2, 32'h00AB_CDEF, "R7");
        cyc(1, 0, 2'd2, 0, "R7");
        cyc(1, 0, 2'd0, 0, "R7");
        // R8: interrupt disabled gives no pulse while wraps continue.
        idle(12);
        cyc(1, 0, 2'd0, 0, "R5");
        // R9: zero reload keeps the counter idle.
        cyc(1, 1, 2'd1, 32'd0, "R9");
        cyc(1, 1, 2'd2, 0, "R9");
        cyc(1, 1, 2'd0, 32'd3, "R9");
        idle(20);
        cyc(1, 0, 2'd2, 0, "R9");
        cyc(1, 0, 2'd0, 0, "R9");
        // Seeded random traffic.
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                3: cyc(1, 0, 2'd0, 0, "R5");
                4: cyc(1, 0, 2'd1, 0, "R10");
                5, 6: cyc(1, 0, 2'd2, 0, "R3");
                7: cyc(1, 1, 2'd1, $urandom % 16, "R4");
                8: begin
                    if ($urandom % 4 == 0) cyc(1, 1, 2'd2, $urandom, "R7");
                    else cyc(1, 1, 2'd0,
                             {$urandom, 1'b0} | (($urandom % 4 != 0) ? 32'd1 : 32'd0),
                             "R2");
                end
                default: cyc(0, 0, 2'd0, 0, "R8");
            endcase
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule